// File: doc/BRIEF.md
# Clock Output Gating Controller

This block is the digital control path of a clock fan-out with five banks of two outputs and one complementary feedback pair. It picks a source clock, divides it per bank, and gates each output. The source is either the PLL-domain clock or, in bypass, one of two reference clocks chosen by a select input. Every bank has its own post-divider, and the feedback pair has a wider ratio set. All source clocks arrive as waveforms and are sampled by a fast system clock `clk`, so every bit of control logic runs in one clocked domain.

Each gate combines a pin with a configuration bit by OR. Disable requests pass through a two-flop synchronizer. A gate changes state only while the divided waveform sits at the park level, so no shortened pulse can appear. A disabled output is either driven at a programmable park level or released to high impedance, which is modelled by a per-output enable. A power-down input stops all outputs. On its release every divider restarts from the same phase.

Top module: `clk_gate_ctrl`

## Requirements
- R1: Bank b is disabled when `bank_dis_pin_i[b]` or `cfg_bank_dis_i[b]` is 1. It is enabled only when both are 0. Bank b drives `q_o[2b]` and `q_o[2b+1]` with the same value.
- R2: A bank enables or disables only in a cycle where its divided waveform equals the park level. A disable never alters the output value at the moment it applies, so no pulse shorter than the divided waveform's own pulses appears.
- R3: Bypass is active when `bypass_pin_i` or `cfg_bypass_i` is 1. The selected reference then feeds all dividers. Otherwise the PLL clock feeds them.
- R4: With bypass active, `ref_sel_i` = 0 selects `ref0_i` and `ref_sel_i` = 1 selects `ref1_i`.
- R5: When `mode_pin_i` or `cfg_hold_i` is 1, every output enable is 1 and disabled outputs are driven at the park level.
- R6: With `cfg_park_lvl_i` = 0 a parked bank output and `fb_o` sit HIGH and `fbn_o` sits LOW. With `cfg_park_lvl_i` = 1 these levels are inverted.
- R7: When `mode_pin_i` and `cfg_hold_i` are both 0, the enables of disabled outputs are 0. This includes the reset state.
- R8: While `pd_n_i` is 0, all bank and feedback outputs are parked within three clock cycles, and the R5/R7 mode logic decides their enables.
- R9: Bank b divides its source by the 2-bit code `bank_div_i[2b+1:2b]`: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 1.
- R10: The feedback pair divides by the value of `fb_div_i` when that value is 1–6, 8, 10 or 12. Any other code gives 1.
- R11: `fbn_o` is always the complement of `fb_o`, and `fb_oe_o` always equals `fbn_oe_o`.
- R12: After `pd_n_i` returns to 1, all dividers restart from a common phase, so banks with the same ratio produce identical outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref0_i | input | 1 | Reference clock 0 |
| ref1_i | input | 1 | Reference clock 1 |
| ref_sel_i | input | 1 | Reference select |
| pll_clk_i | input | 1 | PLL-domain clock |
| pd_n_i | input | 1 | Active-low power-down |
| bypass_pin_i | input | 1 | PLL bypass pin |
| mode_pin_i | input | 1 | Hold-mode pin (park instead of high impedance) |
| bank_dis_pin_i | input | 5 | Per-bank disable pins |
| cfg_bank_dis_i | input | 5 | Per-bank disable configuration bits |
| cfg_bypass_i | input | 1 | Bypass configuration bit |
| cfg_park_lvl_i | input | 1 | Park level select |
| cfg_hold_i | input | 1 | Hold-mode configuration bit |
| bank_div_i | input | 10 | Per-bank divide codes, 2 bits per bank |
| fb_div_i | input | 4 | Feedback divide ratio |
| q_o | output | 10 | Bank output values |
| q_oe_o | output | 10 | Bank output enables |
| fb_o | output | 1 | Feedback output, true side |
| fb_oe_o | output | 1 | Feedback true-side enable |
| fbn_o | output | 1 | Feedback output, complementary side |
| fbn_oe_o | output | 1 | Feedback complementary-side enable |

## Verification
The assertions check four things on every cycle: the complementary relation of the feedback pair, the forced enables in hold mode, the parked outputs during a sustained power-down, and an unchanged output value in the cycle any gate closes outside power-down. Only the bench scenarios can show the frequency results: the division ratios for each source and select path, the mapping of unused codes, the absence of toggling on a disabled bank, the full-width pulses while a disable pin is toggled rapidly, and the phase alignment of equal-ratio banks after power-down exit.

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl #(
  parameter int NBANK = 5,
  parameter int BDW   = 2,
  parameter int FBW   = 4,
  parameter int CW    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref0_i,
  input  logic                 ref1_i,
  input  logic                 ref_sel_i,
  input  logic                 pll_clk_i,
  input  logic                 pd_n_i,
  input  logic                 bypass_pin_i,
  input  logic                 mode_pin_i,
  input  logic [NBANK-1:0]     bank_dis_pin_i,
  input  logic [NBANK-1:0]     cfg_bank_dis_i,
  input  logic                 cfg_bypass_i,
  input  logic                 cfg_park_lvl_i,
  input  logic                 cfg_hold_i,
  input  logic [NBANK*BDW-1:0] bank_div_i,
  input  logic [FBW-1:0]       fb_div_i,
  output logic [2*NBANK-1:0]   q_o,
  output logic [2*NBANK-1:0]   q_oe_o,
  output logic                 fb_o,
  output logic                 fb_oe_o,
  output logic                 fbn_o,
  output logic                 fbn_oe_o
);
  localparam int NCH = NBANK + 1;

  function automatic logic [CW-1:0] bank_ratio(input logic [BDW-1:0] c);
    case (c)
      BDW'(1): return CW'(2);
      BDW'(2): return CW'(4);
      default: return CW'(1);
    endcase
  endfunction

  function automatic logic [CW-1:0] fb_ratio(input logic [FBW-1:0] c);
    case (c)
      FBW'(1), FBW'(2), FBW'(3), FBW'(4), FBW'(5), FBW'(6),
      FBW'(8), FBW'(10), FBW'(12): return CW'(c);
      default: return CW'(1);
    endcase
  endfunction

  logic           bypass, hold, park_hi, src_raw;
  logic [2:0]     src_s;
  logic [1:0]     pd_s;
  logic           src_lvl, src_rise, pd_run;
  logic [NCH-1:0] dis_req, raw, en_q, val;
  logic [CW-1:0]  ratio [NCH];

  assign bypass   = bypass_pin_i | cfg_bypass_i;
  assign hold     = mode_pin_i | cfg_hold_i;
  assign park_hi  = ~cfg_park_lvl_i;
  assign src_raw  = bypass ? (ref_sel_i ? ref1_i : ref0_i) : pll_clk_i;
  assign dis_req  = {1'b0, bank_dis_pin_i | cfg_bank_dis_i};
  assign src_lvl  = src_s[1];
  assign src_rise = src_s[1] & ~src_s[2];
  assign pd_run   = pd_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_s <= '0;
      pd_s  <= '0;
    end else begin
      src_s <= {src_s[1:0], src_raw};
      pd_s  <= {pd_s[0], pd_n_i};
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CW-1:0] cnt, cnt_nx, half;
    logic          dq, en, r;
    logic [1:0]    ds;

    if (g < NBANK) begin : g_bk
      assign ratio[g] = bank_ratio(bank_div_i[g*BDW +: BDW]);
    end else begin : g_fb
      assign ratio[g] = fb_ratio(fb_div_i);
    end

    assign half   = (ratio[g] + CW'(1)) >> 1;
    assign cnt_nx = (cnt >= ratio[g] - CW'(1)) ? '0 : cnt + CW'(1);
    assign r      = (ratio[g] == CW'(1)) ? src_lvl : dq;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
        dq  <= 1'b0;
        ds  <= '0;
        en  <= 1'b0;
      end else begin
        ds <= {ds[0], dis_req[g]};
        if (!pd_run) begin
          cnt <= ratio[g] - CW'(1);
          dq  <= 1'b0;
          en  <= 1'b0;
        end else begin
          if (src_rise) begin
            cnt <= cnt_nx;
            dq  <= (cnt_nx < half);
          end
          if (r == park_hi) en <= ~ds[1];
        end
      end
    end

    assign raw[g]  = r;
    assign en_q[g] = en;
    assign val[g]  = en ? r : park_hi;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_out
    assign q_o[2*b +: 2]    = {2{val[b]}};
    assign q_oe_o[2*b +: 2] = {2{en_q[b] | hold}};
  end

  assign fb_o     = val[NBANK];
  assign fbn_o    = ~val[NBANK];
  assign fb_oe_o  = en_q[NBANK] | hold;
  assign fbn_oe_o = en_q[NBANK] | hold;

endmodule

// File: rtl/clk_gate_ctrl_chk.sv
module clk_gate_ctrl_chk #(
  parameter int NBANK = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pd_n_i,
  input logic               park_lvl,
  input logic               hold,
  input logic               pd_run,
  input logic [NBANK:0]     en,
  input logic [2*NBANK-1:0] q,
  input logic [2*NBANK-1:0] oe,
  input logic               fb,
  input logic               fbn,
  input logic               fb_oe,
  input logic               fbn_oe
);
  a_r11_fb_complement: assert property (@(posedge clk) disable iff (!rst_n)
    fbn == ~fb);

  a_r11_fb_oe_pair: assert property (@(posedge clk) disable iff (!rst_n)
    fb_oe == fbn_oe);

  a_r5_hold_drives: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (&oe && fb_oe));

  a_r8_pd_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_n_i && !$past(pd_n_i) && !$past(pd_n_i, 2) && !$past(pd_n_i, 3))
      |-> (q == {2*NBANK{~park_lvl}} && fb == ~park_lvl));

  for (genvar g = 0; g < NBANK; g++) begin : g_bk
    a_r2_clean_off: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(en[g]) && $past(pd_run) && $stable(park_lvl)) |-> $stable(q[2*g]));
  end

  a_r2_clean_off_fb: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(en[NBANK]) && $past(pd_run) && $stable(park_lvl)) |-> $stable(fb));
endmodule

bind clk_gate_ctrl clk_gate_ctrl_chk #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .pd_n_i(pd_n_i), .park_lvl(cfg_park_lvl_i),
  .hold(hold), .pd_run(pd_run), .en(en_q), .q(q_o), .oe(q_oe_o),
  .fb(fb_o), .fbn(fbn_o), .fb_oe(fb_oe_o), .fbn_oe(fbn_oe_o)
);

// File: tb/clk_gate_ctrl_tb.sv
`timescale 1ns/1ps
module clk_gate_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic ref0 = 0, ref1 = 0, pll = 0;
  logic ref_sel = 0, pd_n = 1, bypass_pin = 0, mode_pin = 0;
  logic [4:0] dis_pin = '0, cfg_dis = '0;
  logic cfg_bypass = 0, cfg_park = 0, cfg_hold = 0;
  logic [9:0] bank_div = '0;
  logic [3:0] fb_div = 4'd1;
  logic [9:0] q, q_oe;
  logic fb, fb_oe, fbn, fbn_oe;

  clk_gate_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ref0_i(ref0), .ref1_i(ref1), .ref_sel_i(ref_sel),
    .pll_clk_i(pll), .pd_n_i(pd_n), .bypass_pin_i(bypass_pin), .mode_pin_i(mode_pin),
    .bank_dis_pin_i(dis_pin), .cfg_bank_dis_i(cfg_dis), .cfg_bypass_i(cfg_bypass),
    .cfg_park_lvl_i(cfg_park), .cfg_hold_i(cfg_hold), .bank_div_i(bank_div),
    .fb_div_i(fb_div), .q_o(q), .q_oe_o(q_oe), .fb_o(fb), .fb_oe_o(fb_oe),
    .fbn_o(fbn), .fbn_oe_o(fbn_oe)
  );

  always #2  clk  = ~clk;
  always #16 pll  = ~pll;
  always #24 ref0 = ~ref0;
  always #40 ref1 = ~ref1;

  localparam int W = 480;
  // {src mode[16:15] (0 pll, 1 pin bypass, 2 cfg bypass), ref_sel[14], bank_div[13:4], fb_div[3:0]}
  localparam logic [16:0] VEC [4] = '{
    {2'd0, 1'b0, 10'b10_01_10_01_00, 4'd12},
    {2'd1, 1'b0, 10'b01_00_11_10_01, 4'd5},
    {2'd2, 1'b1, 10'b11_10_01_00_10, 4'd8},
    {2'd0, 1'b1, 10'b01_11_10_01_00, 4'd7}
  };

  int n_chk = 0, n_fail = 0;
  int rises[6], togs[6];
  int fbn_mis, oe_mis, pair_mis, align_mis;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [5:0] chans();
    logic [5:0] c;
    for (int b = 0; b < 5; b++) c[b] = q[2*b];
    c[5] = fb;
    return c;
  endfunction

  function automatic int bank_r(input logic [1:0] c);
    return (c == 2'b01) ? 2 : (c == 2'b10) ? 4 : 1;
  endfunction

  function automatic int fb_r(input logic [3:0] c);
    if ((c >= 1 && c <= 6) || c == 8 || c == 10 || c == 12) return int'(c);
    return 1;
  endfunction

  task automatic measure(input int w);
    logic [5:0] prevv, cur;
    for (int k = 0; k < 6; k++) begin rises[k] = 0; togs[k] = 0; end
    fbn_mis = 0; oe_mis = 0; pair_mis = 0; align_mis = 0;
    @(negedge clk);
    prevv = chans();
    repeat (w) begin
      @(negedge clk);
      cur = chans();
      for (int k = 0; k < 6; k++) begin
        if (cur[k] && !prevv[k]) rises[k]++;
        if (cur[k] != prevv[k]) togs[k]++;
      end
      if (fbn !== ~fb) fbn_mis++;
      if (fb_oe !== fbn_oe) oe_mis++;
      for (int b = 0; b < 5; b++) if (q[2*b] !== q[2*b+1]) pair_mis++;
      if (q[0] !== q[8]) align_mis++;
      prevv = cur;
    end
  endtask

  // pulse-width monitor for R2
  logic mon_on = 0;
  int hi_run = 0, min_hi = 1000, n_hi = 0;
  logic mon_prev = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (q[0]) hi_run++;
      else if (mon_prev) begin
        if (hi_run < min_hi && n_hi > 0) min_hi = hi_run;
        n_hi++;
        hi_run = 0;
      end
      mon_prev = q[0];
    end
  end

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // reset state: tri-state mode, parked high (R7, R6)
    chk(q_oe === 10'b0 && fb_oe === 1'b0 && fbn_oe === 1'b0, "R7 reset oe", int'(q_oe), 0);
    chk(q === 10'h3FF && fb === 1'b1 && fbn === 1'b0, "R6 reset park", int'(q), 'h3FF);
    rst_n = 1;
    repeat (50) @(negedge clk);

    // vector walk: R3 R4 R9 R10
    foreach (VEC[i]) begin
      logic [16:0] v;
      int per, expv;
      v = VEC[i];
      bypass_pin = (v[16:15] == 2'd1);
      cfg_bypass = (v[16:15] == 2'd2);
      ref_sel    = v[14];
      bank_div   = v[13:4];
      fb_div     = v[3:0];
      per = (v[16:15] == 2'd0) ? 8 : (v[14] ? 20 : 12);
      repeat (100) @(negedge clk);
      measure(W);
      for (int b = 0; b < 5; b++) begin
        expv = W / (per * bank_r(v[4+2*b +: 2]));
        chk(rises[b] >= expv - 1 && rises[b] <= expv + 1,
            $sformatf("R9 R3 R4 vec%0d bank%0d", i, b), rises[b], expv);
      end
      expv = W / (per * fb_r(v[3:0]));
      chk(rises[5] >= expv - 1 && rises[5] <= expv + 1,
          $sformatf("R10 R3 R4 vec%0d fb", i), rises[5], expv);
      chk(fbn_mis == 0 && oe_mis == 0, $sformatf("R11 vec%0d", i), fbn_mis + oe_mis, 0);
      chk(pair_mis == 0, $sformatf("R1 pair vec%0d", i), pair_mis, 0);
    end

    // R1 pin disable, tri-state mode (R7)
    bypass_pin = 0; cfg_bypass = 0; bank_div = 10'b10_01_10_01_00; fb_div = 4'd1;
    dis_pin[1] = 1;
    repeat (100) @(negedge clk);
    measure(200);
    chk(togs[1] == 0, "R1 pin disabled bank stops", togs[1], 0);
    chk(rises[0] >= 24 && rises[0] <= 26, "R1 other bank runs", rises[0], 25);
    chk(q_oe[3:2] == 2'b00 && q_oe[1:0] == 2'b11, "R7 tristate disabled", int'(q_oe[3:0]), 3);
    dis_pin[1] = 0;

    // R1 cfg disable, hold mode (R5), park levels (R6)
    cfg_dis[3] = 1; mode_pin = 1;
    repeat (100) @(negedge clk);
    measure(200);
    chk(togs[3] == 0, "R1 cfg disabled bank stops", togs[3], 0);
    chk(q_oe[7:6] == 2'b11, "R5 hold oe", int'(q_oe[7:6]), 3);
    chk(q[7:6] == 2'b11, "R6 park high", int'(q[7:6]), 3);
    cfg_park = 1;
    repeat (3) @(negedge clk);
    chk(q[7:6] == 2'b00, "R6 park low", int'(q[7:6]), 0);
    cfg_dis[3] = 0; mode_pin = 0;
    repeat (100) @(negedge clk);

    // R2 glitch-free gating: park low, bank0 /4 of pll -> high pulses 16 cycles
    cfg_hold = 1; bank_div[1:0] = 2'b10;
    repeat (100) @(negedge clk);
    mon_on = 1;
    for (int t = 0; t < 90; t++) begin
      dis_pin[0] = ~dis_pin[0];
      repeat (7) @(negedge clk);
    end
    mon_on = 0;
    dis_pin[0] = 0;
    chk(min_hi >= 15, "R2 min high pulse", min_hi, 16);
    chk(n_hi > 5, "R2 pulses seen", n_hi, 6);

    // R8 power-down: tri-state then hold
    cfg_hold = 0; cfg_park = 1;
    bank_div = 10'b01_00_00_00_10;
    repeat (60) @(negedge clk);
    pd_n = 0;
    repeat (5) @(negedge clk);
    chk(q_oe === 10'b0 && fb_oe === 1'b0, "R8 pd tristate", int'(q_oe), 0);
    mode_pin = 1;
    repeat (2) @(negedge clk);
    chk(q_oe === 10'h3FF && q === 10'h000 && fb === 1'b0 && fbn === 1'b1,
        "R8 R6 pd held low", int'(q), 0);
    measure(100);
    chk(togs[0] + togs[2] + togs[4] + togs[5] == 0, "R8 pd no switching",
        togs[0] + togs[2] + togs[4] + togs[5], 0);

    // R12 alignment after pd exit: bank0 and bank4 both /4
    bank_div[9:8] = 2'b10;
    mode_pin = 0;
    repeat (5) @(negedge clk);
    pd_n = 1;
    repeat (60) @(negedge clk);
    measure(400);
    chk(align_mis == 0, "R12 equal ratio aligned", align_mis, 0);
    chk(rises[0] >= 11 && rises[0] <= 13, "R12 banks running", rises[0], 12);
    chk(fbn_mis == 0 && oe_mis == 0, "R11 after pd", fbn_mis + oe_mis, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule